// File: doc/BRIEF.md
# Centralized Scoreboard for Out-of-Order Completion

This block is the hazard controller for a pipeline that issues instructions in order and lets them complete out of order across a small set of functional units. It keeps one status entry per unit and one result-status entry per register. Each cycle it decides whether the decoded instruction at the head of the pipe may issue. It decides which waiting units may read their operands from the register file, and which finished units may write their results back.

An instruction passes through four steps: issue, operand read, execution and result write. Issue is held when the target unit is occupied (structural hazard). It is also held when another in-flight instruction already targets the same destination register, so write-after-write is prevented rather than renamed. A unit reads its operands only when both source ready flags are set. The flags are set by the write-back of the producer, so a consumer always reads from the register file and there is no forwarding. A finished unit is kept from writing back while another unit still has to read the old value of that register (write-after-read).

The block drives no datapath. The functional units report the end of execution with a one-cycle done pulse and follow the grants the block gives them.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is busy, no register has a pending writer, no operand-read or write-back grant is asserted, and an offered instruction is not stalled.
- R2: `iss_stall` is high whenever `iss_valid` is high and the unit selected by `iss_fu` (0 load, 1 add, 2 multiply, 3 divide) holds an instruction.
- R3: `iss_stall` is high whenever `iss_valid` is high and any in-flight instruction targets `iss_dst`, so no two busy units ever share a destination register.
- R4: When `iss_valid` is high and neither R2 nor R3 applies, the instruction issues in that cycle. Each source whose register has a pending writer records that writer's tag (unit index plus one, 0 meaning none) with its ready flag clear. Otherwise the ready flag is set.
- R5: `rd_grant[u]` is high exactly when unit u holds an instruction that has not yet read its operands and both ready flags are set. The read clears both flags, so each instruction gets one grant.
- R6: A consumer's operand-read grant never coincides with its producer's write-back grant. It comes at the earliest in the cycle after that write-back.
- R7: `wb_grant[f]` is withheld while another busy unit still waiting to read has a source equal to f's destination with that source's ready flag set.
- R8: A `fu_done` pulse to a unit that is not executing (idle, or still waiting for operands) has no effect.
- R9: A write-back frees its unit and clears the register's pending-writer entry at the next clock edge. An instruction for that unit or register can issue in the following cycle.
- R10: `wb_grant[f]` is asserted only after a `fu_done` pulse was accepted while f was executing, and it stays high until the cycle it is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A decoded instruction is offered for issue |
| iss_fu | input | 2 | Target unit: 0 load, 1 add, 2 multiply, 3 divide |
| iss_op | input | 4 | Operation code kept in the unit entry |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| fu_done | input | 4 | Per-unit end-of-execution pulse |
| iss_stall | output | 1 | Offered instruction may not issue this cycle |
| rd_grant | output | 4 | Per-unit permission to read operands this cycle |
| wb_grant | output | 4 | Per-unit permission to write the result this cycle |

## Verification
The bench attacks the cycles where two events meet. A write-back that lands in the same cycle as the issue of its consumer must leave the new entry ready; a design that misses this leaves the consumer waiting forever. A write-back held by a still-unread source tests the write-after-read rule, and a design that ignores it lets the result overwrite the old value before it is read. Done pulses aimed at units that are idle or still waiting for operands must be dropped, or results appear before the work is done. The bench also issues to a register or unit in the cycle right after its write-back, which catches designs that free entries a cycle late and stall without cause.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int NUM_FU  = 4;
    parameter int NUM_REG = 8;
    parameter int OP_W    = 4;

    localparam int UID_W = $clog2(NUM_FU + 1);
    localparam int REG_W = $clog2(NUM_REG);
    localparam int SEL_W = $clog2(NUM_FU);

    typedef logic [UID_W-1:0] uid_t;
    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [1:0] {
        PH_WAIT_OPS = 2'd0,
        PH_EXEC     = 2'd1,
        PH_DONE     = 2'd2
    } phase_e;

    typedef struct packed {
        logic            busy;
        phase_e          ph;
        logic [OP_W-1:0] op;
        reg_t            fi;
        reg_t            fj;
        reg_t            fk;
        uid_t            qj;
        uid_t            qk;
        logic            rj;
        logic            rk;
    } fu_stat_t;

    function automatic uid_t unit_tag(input int idx);
        return uid_t'(idx + 1);
    endfunction
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int UNIT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_en,
    input  logic [OP_W-1:0]   op_in,
    input  reg_t              fi_in,
    input  reg_t              fj_in,
    input  reg_t              fk_in,
    input  uid_t              qj_in,
    input  uid_t              qk_in,
    input  logic              done_in,
    input  logic [NUM_FU-1:0] wb_vec,
    output fu_stat_t          st,
    output logic              rd_grant
);
    logic hit_j, hit_k;

    always_comb begin
        hit_j = 1'b0;
        hit_k = 1'b0;
        for (int k = 0; k < NUM_FU; k++) begin
            if (wb_vec[k] && st.qj == unit_tag(k)) hit_j = 1'b1;
            if (wb_vec[k] && st.qk == unit_tag(k)) hit_k = 1'b1;
        end
    end

    assign rd_grant = st.busy && st.ph == PH_WAIT_OPS && st.rj && st.rk;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (issue_en) begin
            st.busy <= 1'b1;
            st.ph   <= PH_WAIT_OPS;
            st.op   <= op_in;
            st.fi   <= fi_in;
            st.fj   <= fj_in;
            st.fk   <= fk_in;
            st.qj   <= qj_in;
            st.qk   <= qk_in;
            st.rj   <= (qj_in == '0);
            st.rk   <= (qk_in == '0);
        end else begin
            if (rd_grant) begin
                st.rj <= 1'b0;
                st.rk <= 1'b0;
                st.ph <= PH_EXEC;
            end
            if (done_in && st.busy && st.ph == PH_EXEC) st.ph <= PH_DONE;
            if (wb_vec[UNIT_IDX]) begin
                st.busy <= 1'b0;
                st.ph   <= PH_WAIT_OPS;
            end
            if (hit_j) begin
                st.qj <= '0;
                st.rj <= 1'b1;
            end
            if (hit_k) begin
                st.qk <= '0;
                st.rk <= 1'b1;
            end
        end
    end

    // R5: one operand read per instruction
    p_read_once_r5: assert property (@(posedge clk) disable iff (rst)
        rd_grant |=> !rd_grant);

    // R8: a done pulse while waiting for operands does not finish the unit
    p_early_done_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (done_in && st.busy && st.ph == PH_WAIT_OPS && !rd_grant) |=> st.ph != PH_DONE);

    // R10: reaching the finished phase requires an accepted done pulse
    p_done_needs_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_DONE && $past(st.ph) != PH_DONE) |-> $past(done_in));

    // R10: a finished unit keeps requesting until it gets write-back
    p_done_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (st.busy && st.ph == PH_DONE && !wb_vec[UNIT_IDX]) |=> (st.busy && st.ph == PH_DONE));
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status
    import sb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_en,
    input  reg_t                          set_reg,
    input  uid_t                          set_tag,
    input  logic [NUM_REG-1:0]            clr_vec,
    output logic [NUM_REG-1:0][UID_W-1:0] stat
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                  stat[r] <= '0;
            else if (set_en && set_reg == reg_t'(r))  stat[r] <= set_tag;
            else if (clr_vec[r])                      stat[r] <= '0;
        end
    end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [SEL_W-1:0]  iss_fu,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    input  logic [NUM_FU-1:0] fu_done,
    output logic              iss_stall,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wb_grant
);
    fu_stat_t                      st [NUM_FU];
    logic [NUM_REG-1:0][UID_W-1:0] reg_stat;
    logic [NUM_REG-1:0]            reg_clr;
    logic [NUM_FU-1:0]             war_hold;
    logic [NUM_FU-1:0]             busy_vec;
    logic                          issue_go;
    uid_t                          tag_j, tag_k;

    for (genvar g = 0; g < NUM_FU; g++) begin : g_busy
        assign busy_vec[g] = st[g].busy;
    end

    assign iss_stall = iss_valid && (busy_vec[iss_fu] || reg_stat[iss_dst] != '0);
    assign issue_go  = iss_valid && !iss_stall;

    // source tags: a producer writing back this cycle counts as already written
    always_comb begin
        tag_j = reg_stat[iss_src1];
        tag_k = reg_stat[iss_src2];
        for (int k = 0; k < NUM_FU; k++) begin
            if (wb_grant[k] && tag_j == unit_tag(k)) tag_j = '0;
            if (wb_grant[k] && tag_k == unit_tag(k)) tag_k = '0;
        end
    end

    // write-after-read: someone still has to read the old value of fi
    always_comb begin
        war_hold = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (u != f && st[u].busy && st[u].ph == PH_WAIT_OPS &&
                    ((st[u].fj == st[f].fi && st[u].rj) ||
                     (st[u].fk == st[f].fi && st[u].rk)))
                    war_hold[f] = 1'b1;
            end
        end
    end

    always_comb begin
        reg_clr = '0;
        for (int f = 0; f < NUM_FU; f++)
            if (wb_grant[f]) reg_clr[st[f].fi] = 1'b1;
    end

    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
        assign wb_grant[g] = st[g].busy && st[g].ph == PH_DONE && !war_hold[g];

        sb_fu_entry #(.UNIT_IDX(g)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .issue_en (issue_go && iss_fu == SEL_W'(g)),
            .op_in    (iss_op),
            .fi_in    (iss_dst),
            .fj_in    (iss_src1),
            .fk_in    (iss_src2),
            .qj_in    (tag_j),
            .qk_in    (tag_k),
            .done_in  (fu_done[g]),
            .wb_vec   (wb_grant),
            .st       (st[g]),
            .rd_grant (rd_grant[g])
        );
    end

    sb_reg_status u_regstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue_go),
        .set_reg (iss_dst),
        .set_tag (unit_tag(int'(iss_fu))),
        .clr_vec (reg_clr),
        .stat    (reg_stat)
    );

    // R1: nothing is granted in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_grant == '0 && wb_grant == '0 && !iss_stall));

    // R2: an occupied unit blocks issue
    p_struct_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && busy_vec[iss_fu]) |-> iss_stall);

    for (genvar i = 0; i < NUM_FU; i++) begin : g_chk_i
        // R9: the unit is free right after its write-back
        p_release_r9: assert property (@(posedge clk) disable iff (rst)
            wb_grant[i] |=> !st[i].busy);

        for (genvar j = 0; j < NUM_FU; j++) begin : g_chk_j
            if (i < j) begin : g_pair
                // R3: two busy units never share a destination
                p_single_writer_r3: assert property (@(posedge clk) disable iff (rst)
                    (st[i].busy && st[j].busy) |-> st[i].fi != st[j].fi);
            end
            if (i != j) begin : g_cross
                // R7: a result is never written while a ready reader of that register waits
                p_war_hold_r7: assert property (@(posedge clk) disable iff (rst)
                    (wb_grant[i] && st[j].busy && st[j].ph == PH_WAIT_OPS && st[j].fj == st[i].fi)
                    |-> !st[j].rj);
                // R6: no forwarding, the consumer reads after the producer's write
                p_no_forward_r6: assert property (@(posedge clk) disable iff (rst)
                    (wb_grant[i] && st[j].busy && (st[j].qj == unit_tag(i) || st[j].qk == unit_tag(i)))
                    |-> !rd_grant[j]);
            end
        end
    end

    // R4: an accepted issue marks the destination as pending
    p_issue_claims_r4: assert property (@(posedge clk) disable iff (rst)
        issue_go |=> reg_stat[$past(iss_dst)] == unit_tag(int'($past(iss_fu))));
endmodule

// File: tb/sb_hazard_ctrl_test.sv
module sb_hazard_ctrl_test;
    import sb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid = 1'b0;
    logic [SEL_W-1:0]  iss_fu = '0;
    logic [OP_W-1:0]   iss_op = '0;
    logic [REG_W-1:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [NUM_FU-1:0] fu_done = '0;
    logic              iss_stall;
    logic [NUM_FU-1:0] rd_grant, wb_grant;

    always #4 clk = ~clk;   // 125 MHz

    sb_hazard_ctrl uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_fu(iss_fu), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2), .fu_done(fu_done),
        .iss_stall(iss_stall), .rd_grant(rd_grant), .wb_grant(wb_grant)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // behavioural reference: phase 0 waiting, 1 executing, 2 finished
    int m_busy[NUM_FU], m_ph[NUM_FU], m_fi[NUM_FU], m_fj[NUM_FU], m_fk[NUM_FU];
    int m_qj[NUM_FU], m_qk[NUM_FU], m_rj[NUM_FU], m_rk[NUM_FU];
    int m_reg[NUM_REG];
    int lat_left[NUM_FU], lat_cfg[NUM_FU];
    bit spur_seen[NUM_FU];
    bit e_stall, freed_prev, rand_lat, spur_en;
    bit e_rd[NUM_FU], e_wb[NUM_FU], e_war[NUM_FU];

    typedef struct { int fu; int dst; int s1; int s2; } ins_t;
    ins_t prog[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        for (int u = 0; u < NUM_FU; u++) begin
            m_busy[u] = 0; m_ph[u] = 0; m_qj[u] = 0; m_qk[u] = 0;
            m_rj[u] = 0; m_rk[u] = 0; lat_left[u] = 0; spur_seen[u] = 0;
        end
        for (int r = 0; r < NUM_REG; r++) m_reg[r] = 0;
        freed_prev = 0;
    endfunction

    function automatic void calc(input bit v, input int fu, input int dst);
        for (int f = 0; f < NUM_FU; f++) begin
            e_war[f] = 0;
            for (int u = 0; u < NUM_FU; u++)
                if (u != f && m_busy[u] && m_ph[u] == 0 &&
                    ((m_fj[u] == m_fi[f] && m_rj[u] != 0) || (m_fk[u] == m_fi[f] && m_rk[u] != 0)))
                    e_war[f] = 1;
            e_wb[f] = m_busy[f] && m_ph[f] == 2 && !e_war[f];
            e_rd[f] = m_busy[f] && m_ph[f] == 0 && m_rj[f] != 0 && m_rk[f] != 0;
        end
        e_stall = v && (m_busy[fu] != 0 || m_reg[dst] != 0);
    endfunction

    function automatic void model_step(input bit v, input int fu, input int dst,
                                       input int s1, input int s2, input logic [NUM_FU-1:0] dn);
        bit any_wb = 0;
        int qa, qb;
        qa = m_reg[s1]; qb = m_reg[s2];
        if (qa != 0 && e_wb[qa-1]) qa = 0;
        if (qb != 0 && e_wb[qb-1]) qb = 0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (e_rd[u]) begin m_rj[u] = 0; m_rk[u] = 0; m_ph[u] = 1; lat_left[u] = lat_cfg[u]; end
            else if (m_busy[u] && m_ph[u] == 1) begin
                if (dn[u]) m_ph[u] = 2;
                else if (lat_left[u] > 0) lat_left[u]--;
            end
        end
        for (int f = 0; f < NUM_FU; f++) if (e_wb[f]) begin
            any_wb = 1;
            m_busy[f] = 0; m_ph[f] = 0; m_reg[m_fi[f]] = 0;
            for (int u = 0; u < NUM_FU; u++) begin
                if (m_qj[u] == f + 1) begin m_qj[u] = 0; m_rj[u] = 1; end
                if (m_qk[u] == f + 1) begin m_qk[u] = 0; m_rk[u] = 1; end
            end
        end
        if (v && !e_stall) begin
            m_busy[fu] = 1; m_ph[fu] = 0; m_fi[fu] = dst; m_fj[fu] = s1; m_fk[fu] = s2;
            m_qj[fu] = qa; m_qk[fu] = qb; m_rj[fu] = (qa == 0); m_rk[fu] = (qb == 0);
            m_reg[dst] = fu + 1; spur_seen[fu] = 0;
            if (rand_lat) lat_cfg[fu] = $urandom % 7;
        end
        freed_prev = any_wb;
    endfunction

    task automatic tick(input bit v, input int fu, input int dst, input int s1, input int s2,
                        input logic [NUM_FU-1:0] dn, output bit accepted);
        string tg;
        iss_valid = v; iss_fu = SEL_W'(fu); iss_dst = REG_W'(dst);
        iss_src1 = REG_W'(s1); iss_src2 = REG_W'(s2); fu_done = dn;
        iss_op = OP_W'($urandom);
        #1;
        calc(v, fu, dst);
        if (e_stall) tg = (m_busy[fu] != 0) ? "R2" : "R3";
        else         tg = freed_prev ? "R9" : "R4";
        check(iss_stall == e_stall, tg, iss_stall, e_stall);
        for (int u = 0; u < NUM_FU; u++) begin
            tg = (m_qj[u] != 0 || m_qk[u] != 0) ? "R6" : "R5";
            check(rd_grant[u] == e_rd[u], tg, rd_grant[u], e_rd[u]);
            if (e_war[u] && m_ph[u] == 2) tg = "R7";
            else if (spur_seen[u])        tg = "R8";
            else                          tg = "R10";
            check(wb_grant[u] == e_wb[u], tg, wb_grant[u], e_wb[u]);
        end
        accepted = v && !e_stall;
        @(posedge clk);
        model_step(v, fu, dst, s1, s2, dn);
        @(negedge clk);
    endtask

    task automatic run_prog();
        bit acc, pending;
        logic [NUM_FU-1:0] dn;
        ins_t h;
        for (int n = 0; n < 20000; n++) begin
            pending = 0;
            for (int u = 0; u < NUM_FU; u++) if (m_busy[u]) pending = 1;
            if (prog.size() == 0 && !pending) break;
            dn = '0;
            for (int u = 0; u < NUM_FU; u++)
                if (m_busy[u] && m_ph[u] == 1 && lat_left[u] == 0) dn[u] = 1'b1;
            if (spur_en && ($urandom % 3) == 0) begin
                int s = $urandom % NUM_FU;
                if (!(m_busy[s] && m_ph[s] == 1)) begin
                    dn[s] = 1'b1;
                    if (m_busy[s]) spur_seen[s] = 1;
                end
            end
            if (prog.size() > 0) begin
                h = prog[0];
                tick(1, h.fu, h.dst, h.s1, h.s2, dn, acc);
                if (acc) void'(prog.pop_front());
            end else begin
                tick(0, 0, 0, 0, 0, dn, acc);
            end
        end
    endtask

    function automatic void add(input int fu, input int dst, input int s1, input int s2);
        ins_t t;
        t.fu = fu; t.dst = dst; t.s1 = s1; t.s2 = s2;
        prog.push_back(t);
    endfunction

    initial begin
        bit acc;
        model_reset();
        lat_cfg[0] = 1; lat_cfg[1] = 2; lat_cfg[2] = 10; lat_cfg[3] = 40;
        rand_lat = 0; spur_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet state right after reset, an instruction offered is accepted
        #1;
        check(rd_grant == '0, "R1", rd_grant, 0);
        check(wb_grant == '0, "R1", wb_grant, 0);
        iss_valid = 1'b1; iss_fu = 2'd1; iss_dst = 3'd1;
        #1;
        check(iss_stall == 1'b0, "R1", iss_stall, 0);
        iss_valid = 1'b0;
        @(negedge clk);

        // load/mul/sub/div/add mix: structural stalls, WAR hold on r6 (R2 R7)
        add(0, 6, 0, 0);  add(0, 2, 0, 0);  add(2, 0, 2, 4);
        add(1, 7, 6, 2);  add(3, 5, 0, 6);  add(1, 6, 7, 2);
        run_prog();

        // WAW: second writer of r1 waits for the first (R3), then issues (R9)
        add(2, 1, 2, 3);  add(1, 1, 4, 5);  add(0, 3, 1, 1);
        run_prog();

        // spurious done pulses while waiting or idle (R8)
        spur_en = 1;
        lat_cfg[0] = 5;
        add(0, 3, 0, 0);  add(1, 4, 3, 3);  add(2, 5, 4, 3);  add(3, 6, 5, 4);
        run_prog();

        // random stream with random latencies
        rand_lat = 1;
        for (int i = 0; i < 300; i++) add($urandom % 4, $urandom % 8, $urandom % 8, $urandom % 8);
        run_prog();
        spur_en = 0;
        for (int i = 0; i < 200; i++) add($urandom % 4, $urandom % 8, $urandom % 8, $urandom % 8);
        run_prog();

        tick(0, 0, 0, 0, 0, '0, acc);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule